// File: doc/BRIEF.md
# Pulse-Width Frame Decoder

This block recovers reader-to-card frames from a demodulated carrier-level input. Each bit is carried by the spacing between consecutive rising edges of that input. A cycle counter measures each spacing. The block classifies the spacing as a one, a zero or an illegal interval, and packs the bits into a frame word. The frame closes either when the line stays quiet for too long or when an illegal interval arrives. The block then presents the frame word, its bit count and a one-cycle valid strobe.

The input is asynchronous, so it passes through a two-flop synchroniser before edge detection. The clock cycle is the tick. A small session tracker watches the length and content of each emitted frame. It moves from disconnected to initialised to connected, and the block reports a frame-kind code with every frame. Analog demodulation, keystream handling and memory access belong to other blocks.

Top module: `pwd_frame_decoder`

## Requirements
- R1: After reset, frameValid, frameBad, frameData, frameLen and frameKind are 0, and sessState is 0 (disconnected).
- R2: An interval strictly between ONE_TICKS-TOL_TICKS and ONE_TICKS+TOL_TICKS decodes as a 1. An interval strictly between ZERO_TICKS-TOL_TICKS and ZERO_TICKS+TOL_TICKS decodes as a 0. The i-th decoded bit of a frame lands in frameData bit i, least significant first.
- R3: While no frame is in progress, an interval that matches neither window produces no frame. The rising edge that ends it only becomes the new timing reference.
- R4: While a frame is in progress, an interval that matches neither window emits the frame at once with frameBad=1, carrying the bits gathered so far.
- R5: When no rising edge follows the last one within ONE_TICKS+TOL_TICKS cycles, the frame is emitted with frameBad=0. frameValid rises on the (ONE_TICKS+TOL_TICKS+3)-th rising clock edge, counting from the first edge at which the input's final rise is present. This count includes the synchroniser.
- R6: frameValid is high for exactly one cycle per frame. The bit count restarts from zero, so the next frame's data and length do not include earlier bits.
- R7: Bits beyond the 31st are dropped. frameLen stays 31, and frameData holds the first 31 bits with bit 31 at 0.
- R8: frameKind is 1 for a 7-bit frame (init), 2 for 6 bits (acknowledge), 3 for 11 bits (read request), 4 for 23 bits (write request), and 0 for any other length.
- R9: sessState is encoded 0 = disconnected, 1 = initialised and 2 = connected. It changes on each emitted frame by these rules:
  - A 7-bit frame equal to IV_CODE goes to 1 from any state.
  - In state 1, a 6-bit frame equal to ACK_CODE goes to 2, and any other frame goes to 0.
  - Otherwise a 23-bit frame goes to 0.
  - All other frames leave the state unchanged.
- R10: The interval counter stops once it exceeds 20*ONE_TICKS. After an idle period longer than that, the next frame still decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one tick |
| rstN | input | 1 | Active-low synchronous reset |
| rxLevel | input | 1 | Demodulated carrier level, asynchronous |
| frameValid | output | 1 | One-cycle strobe for an emitted frame |
| frameData | output | 32 | Frame bits, first received bit in bit 0 |
| frameLen | output | 5 | Number of bits in the frame |
| frameBad | output | 1 | Frame was ended by an illegal interval |
| frameKind | output | 3 | Length class of the frame (see R8) |
| sessState | output | 2 | Session state (see R9) |

## Verification
The hardest cases to reach from the ports are intervals one tick inside each edge of the tolerance windows, and the exact cycle of the timeout close. Both depend on the two-flop synchroniser adding the same delay to every edge. The bench drives every edge at a falling clock edge. It builds each interval by counting falling edges from the previous rise, so any spacing can be placed to the cycle. The stimulus covers window-edge intervals (81, 119, 41, 79 ticks) and an illegal 80-tick interval in mid-frame. It also covers a 33-bit frame that overruns the packer, and a quiet line longer than the counter's stop point.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  localparam int FRAME_W  = 32;
  localparam int LEN_W    = 5;
  localparam int MAX_BITS = 31;

  localparam int LEN_INIT  = 7;
  localparam int LEN_ACK   = 6;
  localparam int LEN_READ  = 11;
  localparam int LEN_WRITE = 23;

  typedef enum logic [1:0] {
    SESS_DISC = 2'd0,
    SESS_INIT = 2'd1,
    SESS_CONN = 2'd2
  } sessState_t;

  typedef enum logic [2:0] {
    KIND_OTHER = 3'd0,
    KIND_INIT  = 3'd1,
    KIND_ACK   = 3'd2,
    KIND_READ  = 3'd3,
    KIND_WRITE = 3'd4
  } frameKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;   // append bitVal to the frame word
    logic bitVal;
    logic close;   // emit the frame and clear the accumulator
    logic bad;     // frame ended by an illegal interval
  } dpCtrl_t;

endpackage

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int STOP_LIMIT = 2000,
  parameter int CNT_W      = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxLevel,
  input  dpCtrl_t            ctrl,
  output logic               rise,
  output logic [CNT_W-1:0]   cnt,
  output logic [FRAME_W-1:0] accData,
  output logic [LEN_W-1:0]   accLen,
  output logic               frameValid,
  output logic [FRAME_W-1:0] frameData,
  output logic [LEN_W-1:0]   frameLen,
  output logic               frameBad
);

  localparam logic [CNT_W-1:0] STOP_CNT = CNT_W'(STOP_LIMIT);
  localparam logic [LEN_W-1:0] LEN_CAP  = LEN_W'(MAX_BITS);

  // [0],[1]: synchroniser, [2]: previous level for edge detection
  logic [2:0] syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1:0], rxLevel};
  end

  assign rise = syncQ[1] & ~syncQ[2];

  // interval counter: restarts at 1 on a rise so it reads the edge spacing
  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (rise)            cnt <= CNT_W'(1);
    else if (cnt <= STOP_CNT) cnt <= cnt + CNT_W'(1);
  end

  // frame accumulator, least significant bit first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accData <= '0;
      accLen  <= '0;
    end else if (ctrl.close) begin
      accData <= '0;
      accLen  <= '0;
    end else if (ctrl.shift && (accLen != LEN_CAP)) begin
      accData[accLen] <= ctrl.bitVal;
      accLen          <= accLen + LEN_W'(1);
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      frameData  <= '0;
      frameLen   <= '0;
      frameBad   <= 1'b0;
    end else begin
      frameValid <= ctrl.close;
      if (ctrl.close) begin
        frameData <= accData;
        frameLen  <= accLen;
        frameBad  <= ctrl.bad;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid); // R6
  AST_LEN_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (accLen == '0)); // R6
  AST_LEN_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (accLen == LEN_CAP && ctrl.shift && !ctrl.close) |=> (accLen == LEN_CAP)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= STOP_CNT + CNT_W'(1)); // R10

endmodule

// File: rtl/pwd_control.sv
module pwd_control
  import pwd_pkg::*;
#(
  parameter int ONE_TICKS  = 100,
  parameter int ZERO_TICKS = 60,
  parameter int TOL_TICKS  = 20,
  parameter int CNT_W      = 11,
  parameter int IV_CODE    = 85,
  parameter int ACK_CODE   = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rise,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [FRAME_W-1:0] accData,
  input  logic [LEN_W-1:0]   accLen,
  output dpCtrl_t            ctrl,
  output frameKind_t         frameKind,
  output sessState_t         sessState
);

  localparam logic [CNT_W-1:0]   CLOSE_CNT = CNT_W'(ONE_TICKS + TOL_TICKS);
  localparam logic [FRAME_W-1:0] IV_WORD   = FRAME_W'(IV_CODE);
  localparam logic [FRAME_W-1:0] ACK_WORD  = FRAME_W'(ACK_CODE);

  logic active;
  logic matchOne, matchZero;
  int   cntI;

  assign cntI      = int'(cnt);
  assign matchOne  = (cntI > ONE_TICKS - TOL_TICKS)  && (cntI < ONE_TICKS + TOL_TICKS);
  assign matchZero = (cntI > ZERO_TICKS - TOL_TICKS) && (cntI < ZERO_TICKS + TOL_TICKS);

  always_comb begin
    ctrl = '0;
    if (rise) begin
      if (matchOne) begin
        ctrl.shift  = 1'b1;
        ctrl.bitVal = 1'b1;
      end else if (matchZero) begin
        ctrl.shift  = 1'b1;
      end else if (active) begin
        ctrl.close  = 1'b1;
        ctrl.bad    = 1'b1;
      end
    end else if (active && (cnt == CLOSE_CNT)) begin
      ctrl.close = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           active <= 1'b0;
    else if (ctrl.close) active <= 1'b0;
    else if (ctrl.shift) active <= 1'b1;
  end

  // length classification
  frameKind_t kindNext;
  always_comb begin
    unique case (int'(accLen))
      LEN_INIT:  kindNext = KIND_INIT;
      LEN_ACK:   kindNext = KIND_ACK;
      LEN_READ:  kindNext = KIND_READ;
      LEN_WRITE: kindNext = KIND_WRITE;
      default:   kindNext = KIND_OTHER;
    endcase
  end

  // session tracking
  sessState_t sessNext;
  always_comb begin
    sessNext = sessState;
    if (int'(accLen) == LEN_INIT && accData == IV_WORD)
      sessNext = SESS_INIT;
    else if (sessState == SESS_INIT)
      sessNext = (int'(accLen) == LEN_ACK && accData == ACK_WORD) ? SESS_CONN : SESS_DISC;
    else if (int'(accLen) == LEN_WRITE)
      sessNext = SESS_DISC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameKind <= KIND_OTHER;
      sessState <= SESS_DISC;
    end else if (ctrl.close) begin
      frameKind <= kindNext;
      sessState <= sessNext;
    end
  end

  AST_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.close && int'(accLen) == LEN_WRITE && sessState != SESS_INIT) |=> (sessState == SESS_DISC)); // R9
  AST_ACK_CONNECTS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.close && sessState == SESS_INIT && int'(accLen) == LEN_ACK && accData == ACK_WORD)
      |=> (sessState == SESS_CONN)); // R9

endmodule

// File: rtl/pwd_frame_decoder.sv
module pwd_frame_decoder
  import pwd_pkg::*;
#(
  parameter int ONE_TICKS  = 100,
  parameter int ZERO_TICKS = 60,
  parameter int TOL_TICKS  = 20,
  parameter int IV_CODE    = 85,
  parameter int ACK_CODE   = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxLevel,
  output logic        frameValid,
  output logic [31:0] frameData,
  output logic [4:0]  frameLen,
  output logic        frameBad,
  output logic [2:0]  frameKind,
  output logic [1:0]  sessState
);

  localparam int STOP_LIMIT = 20 * ONE_TICKS;
  localparam int CNT_W      = $clog2(STOP_LIMIT + 2);

  dpCtrl_t            ctrl;
  logic               rise;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] accData;
  logic [LEN_W-1:0]   accLen;
  frameKind_t         kindQ;
  sessState_t         sessQ;

  pwd_datapath #(
    .STOP_LIMIT (STOP_LIMIT),
    .CNT_W      (CNT_W)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .rxLevel    (rxLevel),
    .ctrl       (ctrl),
    .rise       (rise),
    .cnt        (cnt),
    .accData    (accData),
    .accLen     (accLen),
    .frameValid (frameValid),
    .frameData  (frameData),
    .frameLen   (frameLen),
    .frameBad   (frameBad)
  );

  pwd_control #(
    .ONE_TICKS  (ONE_TICKS),
    .ZERO_TICKS (ZERO_TICKS),
    .TOL_TICKS  (TOL_TICKS),
    .CNT_W      (CNT_W),
    .IV_CODE    (IV_CODE),
    .ACK_CODE   (ACK_CODE)
  ) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .rise      (rise),
    .cnt       (cnt),
    .accData   (accData),
    .accLen    (accLen),
    .ctrl      (ctrl),
    .frameKind (kindQ),
    .sessState (sessQ)
  );

  assign frameKind = kindQ;
  assign sessState = sessQ;

  AST_KIND_INIT: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameLen == 5'd7) |-> (frameKind == 3'd1)); // R8
  AST_KIND_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameLen == 5'd23) |-> (frameKind == 3'd4)); // R8

endmodule

// File: tb/tb_pwd_frame_decoder.sv
module tb_pwd_frame_decoder;

  localparam int ONE   = 100;
  localparam int ZERO  = 60;
  localparam int TOL   = 20;
  localparam int PAUSE = 10;
  localparam int NV    = 8;

  // stimulus/expectation table: bit count, bits, kind, session after
  localparam int VN [NV] = '{7, 6, 11, 23, 7, 6, 11, 5};
  localparam int VD [NV] = '{'h55, 'h19, 'h2A5, 'h12345, 'h55, 'h05, 'h1F0, 'h16};
  localparam int VK [NV] = '{1, 2, 3, 4, 1, 2, 3, 0};
  localparam int VS [NV] = '{1, 2, 2, 0, 1, 0, 0, 0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLevel = 1'b1;
  logic        frameValid;
  logic [31:0] frameData;
  logic [4:0]  frameLen;
  logic        frameBad;
  logic [2:0]  frameKind;
  logic [1:0]  sessState;

  int tests = 0;
  int fails = 0;
  int gotCount = 0;
  bit done = 1'b0;
  logic [31:0] capData;
  logic [4:0]  capLen;
  logic        capBad;
  logic [2:0]  capKind;
  logic [1:0]  capSess;

  always #5 clk = ~clk;

  pwd_frame_decoder dut (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel),
    .frameValid(frameValid), .frameData(frameData), .frameLen(frameLen),
    .frameBad(frameBad), .frameKind(frameKind), .sessState(sessState)
  );

  always @(negedge clk) begin
    if (frameValid) begin
      capData  <= frameData;
      capLen   <= frameLen;
      capBad   <= frameBad;
      capKind  <= frameKind;
      capSess  <= sessState;
      gotCount <= gotCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reference();
    rxLevel = 1'b0;
    repeat (PAUSE) @(negedge clk);
    rxLevel = 1'b1;
  endtask

  task automatic interval(input int p);
    repeat (p - PAUSE) @(negedge clk);
    rxLevel = 1'b0;
    repeat (PAUSE) @(negedge clk);
    rxLevel = 1'b1;
  endtask

  task automatic sendFrame(input int n, input logic [63:0] bits);
    reference();
    for (int i = 0; i < n; i++) interval(bits[i] ? ONE : ZERO);
  endtask

  task automatic waitFrame(input int start);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (gotCount != start) break;
    end
    repeat (2) @(negedge clk);
    repeat (50) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int start;
    int c;
    logic [63:0] pat;
    logic [31:0] expPat;

    repeat (4) @(negedge clk);
    // R1 reset state
    check(frameValid == 0 && frameBad == 0, "R1", "valid/bad", {frameValid, frameBad}, 0);
    check(frameData == 0 && frameLen == 0, "R1", "data/len", frameData, 0);
    check(frameKind == 0 && sessState == 0, "R1", "kind/session", {frameKind, sessState}, 0);
    rstN = 1'b1;
    repeat (300) @(negedge clk);

    // R3 lone reference edge and idle non-matching interval make no frame
    start = gotCount;
    reference();
    interval(30);
    repeat (400) @(negedge clk);
    check(gotCount == start, "R3", "frames after idle edges", gotCount - start, 0);

    // table walk: R2 R8 R9
    for (int v = 0; v < NV; v++) begin
      start = gotCount;
      sendFrame(VN[v], 64'(VD[v]));
      waitFrame(start);
      check(gotCount == start + 1 && capBad == 0, "R2", "frame emitted good", capBad, 0);
      check(capData == 32'(VD[v]) && capLen == 5'(VN[v]), "R2", "data", capData, VD[v]);
      check(capKind == 3'(VK[v]), "R8", "kind", capKind, VK[v]);
      check(capSess == 2'(VS[v]), "R9", "session", capSess, VS[v]);
    end

    // R2 window edges: 119,81 -> 1; 79,41 -> 0
    start = gotCount;
    reference();
    interval(ONE + TOL - 1); interval(ONE - TOL + 1);
    interval(ZERO + TOL - 1); interval(ZERO - TOL + 1);
    waitFrame(start);
    check(capData == 32'h3 && capLen == 5'd4 && capBad == 0, "R2", "window edges", capData, 3);

    // R4 illegal interval mid-frame
    start = gotCount;
    reference();
    interval(ONE); interval(ZERO); interval(ONE);
    interval(80);
    waitFrame(start);
    check(capBad == 1 && capLen == 5'd3 && capData == 32'h5, "R4", "bad frame", capData, 5);
    repeat (300) @(negedge clk);
    check(gotCount == start + 1, "R4", "single emit after bad", gotCount - start, 1);

    // R7 overlong frame of 33 bits
    pat = '0;
    for (int i = 0; i < 33; i++) pat[i] = (i % 3 == 0);
    expPat = pat[31:0];
    expPat[31] = 1'b0;
    start = gotCount;
    sendFrame(33, pat);
    waitFrame(start);
    check(capLen == 5'd31 && capData == expPat, "R7", "overlong", capData, expPat);

    // R5 timeout close cycle, R6 single-cycle strobe
    start = gotCount;
    sendFrame(2, 64'h1);
    c = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      c++;
      @(negedge clk);
      if (frameValid) break;
    end
    check(c == ONE + TOL + 3, "R5", "close cycle", c, ONE + TOL + 3);
    check(frameBad == 0 && frameLen == 5'd2, "R5", "closed good", frameLen, 2);
    @(negedge clk);
    check(frameValid == 0, "R6", "strobe width", frameValid, 0);
    repeat (60) @(negedge clk);
    start = gotCount;
    sendFrame(3, 64'h6);
    waitFrame(start);
    check(capLen == 5'd3 && capData == 32'h6, "R6", "fresh frame", capData, 6);

    // R10 long idle past the stop point, then decode
    repeat (20 * ONE + 600) @(negedge clk);
    start = gotCount;
    sendFrame(4, 64'h9);
    waitFrame(start);
    check(gotCount == start + 1 && capLen == 5'd4 && capData == 32'h9, "R10", "after long idle", capData, 9);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule